// File: doc/BRIEF.md
# Preloaded Write-Behind Window Cache

This block sits between client logic and a slower external memory. It keeps a fixed window of `LINES` words, starting at external word address `BASE`, in on-chip storage. Right after reset it fills the whole window by reading the external memory, one word at a time. After that it serves every client read and write from its local copy, and it completes each request in one cycle.

A client write only marks its line dirty. A background writer then walks the lines in ascending index order, wrapping at the end, and copies dirty lines out to the external memory with at most one external request in flight. Logic that has to reset the FPGA while the external memory keeps power raises `drain_req`. It then waits for `drain_done`, which guarantees that the external window holds every client write. The client port uses the same valid/ready request and response signals as the memory port, so either can be connected in place of the other.

Top module: `wb_window_cache`

## Requirements
- R1: After reset, `req_ready` stays low until the preload is complete. The preload reads external addresses `BASE+0` through `BASE+LINES-1` in ascending order, one request at a time.
- R2: When a read request is accepted (`req_valid && req_ready`), `rsp_valid` is high for exactly the next cycle. `rsp_rdata` then carries the line's current contents: the preloaded word, or the last word a client wrote to that line.
- R3: A write is accepted and acknowledged without waiting for the external memory. `rsp_valid` pulses the next cycle with `rsp_rdata` equal to the written word, and later reads of that line return it.
- R4: The line index is the low `log2(LINES)` bits of `req_addr`. The higher address bits are ignored.
- R5: Every client write eventually reaches external address `BASE+index` with the line's latest data.
- R6: The memory port has at most one outstanding request. A request that is not yet accepted keeps `mem_req_valid` high and keeps its address stable.
- R7: Background write-backs visit lines in ascending index order and wrap from `LINES-1` to 0.
- R8: `drain_done` is high only while `drain_req` is high, the preload is complete, no line is dirty and no write-back is in flight. At that point the external window equals the cache contents.
- R9: While `drain_req` is high, write requests see `req_ready` low, and read requests are still served.
- R10: If a client writes a line while that line's write-back is in flight, the line stays dirty and is written back again with the new data.
- R11: A client write sets the line's dirty flag, so `drain_done` stays low right after a write until that line's write-back is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Client request accepted this cycle when high with req_valid |
| req_we | input | 1 | Client request is a write |
| req_addr | input | AW | Client word address; low bits select the line |
| req_wdata | input | DW | Client write data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | DW | Read data, or echoed write data |
| drain_req | input | 1 | Request to flush all dirty lines |
| drain_done | output | 1 | No dirty data remains while draining |
| mem_req_valid | output | 1 | External request valid |
| mem_req_ready | input | 1 | External memory accepts the request |
| mem_req_we | output | 1 | External request is a write |
| mem_req_addr | output | AW | External word address |
| mem_req_wdata | output | DW | External write data |
| mem_rsp_valid | input | 1 | External response (read data or write acknowledge) |
| mem_rsp_rdata | input | DW | External read data |

## Verification
The bench builds the cache with `LINES=8`, `AW=12`, `DW=16` and `BASE=0x040`. With eight lines, random client addresses hit every line many times, and the scanner wraps often within a short run. The twelve-bit address leaves plenty of upper bits to prove that they are ignored. The non-zero base exposes any offset error in the external addresses. The bench's memory model has adjustable response latency. Long latencies hold a write-back in flight long enough to rewrite the same line, and they let the bench dirty every line before the scanner catches up, so the visiting order can be observed during a drain.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    // Phases of the external-memory sequencer.
    typedef enum logic [2:0] {
        SQ_LOAD_REQ,
        SQ_LOAD_WAIT,
        SQ_SCAN,
        SQ_WB_REQ,
        SQ_WB_WAIT
    } seq_state_e;

    function automatic logic in_preload(input seq_state_e st);
        return (st == SQ_LOAD_REQ) || (st == SQ_LOAD_WAIT);
    endfunction

    function automatic logic in_writeback(input seq_state_e st);
        return (st == SQ_WB_REQ) || (st == SQ_WB_WAIT);
    endfunction

endpackage

// File: rtl/wbc_store.sv
module wbc_store #(
    parameter int DW    = 32,
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [DW-1:0]    rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [DW-1:0]    rd_data_b,
    input  logic             dirty_set,
    input  logic [IDX_W-1:0] dirty_set_idx,
    input  logic             dirty_clr,
    input  logic [IDX_W-1:0] dirty_clr_idx,
    output logic [LINES-1:0] dirty
);
    logic [DW-1:0]    line_q [LINES];
    logic [LINES-1:0] dirty_d;

    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_idx] <= wr_data;
    end

    assign rd_data_a = line_q[rd_idx_a];
    assign rd_data_b = line_q[rd_idx_b];

    // A set in the same cycle as a clear on the same line wins.
    always_comb begin
        dirty_d = dirty;
        if (dirty_clr) dirty_d[dirty_clr_idx] = 1'b0;
        if (dirty_set) dirty_d[dirty_set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) dirty <= '0;
        else     dirty <= dirty_d;
    end
endmodule

// File: rtl/wbc_front.sv
module wbc_front #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loaded,
    input  logic             drain_req,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [IDX_W-1:0] st_idx,
    input  logic [DW-1:0]    st_rdata,
    output logic             cli_wr_en,
    output logic [DW-1:0]    cli_wdata
);
    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
    } cli_req_t;

    cli_req_t cur;
    logic     accept;

    assign cur.we   = req_we;
    assign cur.idx  = req_addr[IDX_W-1:0];
    assign cur.data = req_wdata;

    // Writes wait while a drain is pending; reads always pass once loaded.
    assign req_ready = loaded && !(drain_req && cur.we);
    assign accept    = req_valid && req_ready;

    assign st_idx    = cur.idx;
    assign cli_wr_en = accept && cur.we;
    assign cli_wdata = cur.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) rsp_rdata <= cur.we ? cur.data : st_rdata;
        end
    end
endmodule

// File: rtl/wbc_seq.sv
module wbc_seq
    import wbc_pkg::*;
#(
    parameter int          AW    = 16,
    parameter int          DW    = 32,
    parameter int          LINES = 16,
    parameter logic [AW-1:0] BASE = '0,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_we,
    output logic [AW-1:0]    mem_req_addr,
    output logic [DW-1:0]    mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [DW-1:0]    mem_rsp_rdata,
    input  logic [LINES-1:0] dirty,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [DW-1:0]    rd_data,
    output logic             load_en,
    output logic [IDX_W-1:0] load_idx,
    output logic [DW-1:0]    load_data,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    input  logic             cli_wr_en,
    input  logic [IDX_W-1:0] cli_idx,
    output logic             loaded,
    output logic             wb_busy
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [IDX_W-1:0] wb_idx_q, wb_idx_d;
    logic [DW-1:0]    wb_data_q, wb_data_d;
    logic             redirty_q, redirty_d;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
        return (i == LAST) ? '0 : i + 1'b1;
    endfunction

    assign loaded  = !in_preload(state_q);
    assign wb_busy = in_writeback(state_q);

    always_comb begin
        state_d       = state_q;
        ptr_d         = ptr_q;
        wb_idx_d      = wb_idx_q;
        wb_data_d     = wb_data_q;
        redirty_d     = redirty_q;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = BASE + AW'(ptr_q);
        mem_req_wdata = wb_data_q;
        load_en       = 1'b0;
        load_idx      = ptr_q;
        load_data     = mem_rsp_rdata;
        clr_en        = 1'b0;
        clr_idx       = wb_idx_q;
        rd_idx        = ptr_q;
        unique case (state_q)
            SQ_LOAD_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = SQ_LOAD_WAIT;
            end
            SQ_LOAD_WAIT: begin
                if (mem_rsp_valid) begin
                    load_en = 1'b1;
                    ptr_d   = step(ptr_q);
                    state_d = (ptr_q == LAST) ? SQ_SCAN : SQ_LOAD_REQ;
                end
            end
            SQ_SCAN: begin
                if (dirty[ptr_q]) begin
                    wb_idx_d  = ptr_q;
                    wb_data_d = rd_data;
                    redirty_d = cli_wr_en && (cli_idx == ptr_q);
                    state_d   = SQ_WB_REQ;
                end else begin
                    ptr_d = step(ptr_q);
                end
            end
            SQ_WB_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = BASE + AW'(wb_idx_q);
                if (cli_wr_en && (cli_idx == wb_idx_q)) redirty_d = 1'b1;
                if (mem_req_ready) state_d = SQ_WB_WAIT;
            end
            SQ_WB_WAIT: begin
                mem_req_addr = BASE + AW'(wb_idx_q);
                if (cli_wr_en && (cli_idx == wb_idx_q)) redirty_d = 1'b1;
                if (mem_rsp_valid) begin
                    clr_en  = !redirty_q;
                    ptr_d   = step(wb_idx_q);
                    state_d = SQ_SCAN;
                end
            end
            default: state_d = SQ_LOAD_REQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_LOAD_REQ;
            ptr_q     <= '0;
            wb_idx_q  <= '0;
            wb_data_q <= '0;
            redirty_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ptr_q     <= ptr_d;
            wb_idx_q  <= wb_idx_d;
            wb_data_q <= wb_data_d;
            redirty_q <= redirty_d;
        end
    end
endmodule

// File: rtl/wb_window_cache.sv
module wb_window_cache #(
    parameter int            AW    = 16,
    parameter int            DW    = 32,
    parameter int            LINES = 16,
    parameter logic [AW-1:0] BASE  = 16'h0200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          drain_req,
    output logic          drain_done,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata
);
    localparam int IDX_W = $clog2(LINES);

    logic             loaded, wb_busy;
    logic [LINES-1:0] dirty;
    logic [IDX_W-1:0] cli_idx, seq_rd_idx, load_idx, clr_idx;
    logic [DW-1:0]    cli_rdata, seq_rd_data, load_data, cli_wdata;
    logic             cli_wr_en, load_en, clr_en;
    logic             st_wr_en;
    logic [IDX_W-1:0] st_wr_idx;
    logic [DW-1:0]    st_wr_data;

    // Preload and client writes never overlap: clients wait for loaded.
    assign st_wr_en   = load_en || cli_wr_en;
    assign st_wr_idx  = load_en ? load_idx  : cli_idx;
    assign st_wr_data = load_en ? load_data : cli_wdata;

    assign drain_done = drain_req && loaded && !(|dirty) && !wb_busy;

    wbc_store #(.DW(DW), .LINES(LINES)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_data(st_wr_data),
        .rd_idx_a(cli_idx), .rd_data_a(cli_rdata),
        .rd_idx_b(seq_rd_idx), .rd_data_b(seq_rd_data),
        .dirty_set(cli_wr_en), .dirty_set_idx(cli_idx),
        .dirty_clr(clr_en), .dirty_clr_idx(clr_idx),
        .dirty(dirty)
    );

    wbc_front #(.AW(AW), .DW(DW), .LINES(LINES)) u_front (
        .clk(clk), .rst(rst), .loaded(loaded), .drain_req(drain_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .st_idx(cli_idx), .st_rdata(cli_rdata),
        .cli_wr_en(cli_wr_en), .cli_wdata(cli_wdata)
    );

    wbc_seq #(.AW(AW), .DW(DW), .LINES(LINES), .BASE(BASE)) u_seq (
        .clk(clk), .rst(rst),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .dirty(dirty), .rd_idx(seq_rd_idx), .rd_data(seq_rd_data),
        .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .cli_wr_en(cli_wr_en), .cli_idx(cli_idx),
        .loaded(loaded), .wb_busy(wb_busy)
    );
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst,
    input logic             loaded,
    input logic             wb_busy,
    input logic [LINES-1:0] dirty,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_we,
    input logic [AW-1:0]    req_addr,
    input logic             rsp_valid,
    input logic             drain_req,
    input logic             drain_done,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [AW-1:0]    mem_req_addr,
    input logic             mem_rsp_valid
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)                                outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
        else if (mem_rsp_valid)                 outstanding <= 1'b0;
    end

    AST_NO_CLIENT_DURING_LOAD: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> !req_ready); // R1

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid); // R2

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid); // R3

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !outstanding); // R6

    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R6

    AST_DRAIN_CLEAN: assert property (@(posedge clk) disable iff (rst)
        drain_done |-> (dirty == '0 && !wb_busy && drain_req)); // R8

    AST_DRAIN_STALLS_WRITES: assert property (@(posedge clk) disable iff (rst)
        (drain_req && req_we) |-> !req_ready); // R9

    AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_we) |=> dirty[$past(req_addr[IDX_W-1:0])]); // R11
endmodule

bind wb_window_cache wbc_checker #(.AW(AW), .DW(DW), .LINES(LINES)) u_chk (
    .clk(clk), .rst(rst), .loaded(loaded), .wb_busy(wb_busy), .dirty(dirty),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .rsp_valid(rsp_valid),
    .drain_req(drain_req), .drain_done(drain_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/tb_wb_window_cache.sv
module tb_wb_window_cache;
    localparam int            AW    = 12;
    localparam int            DW    = 16;
    localparam int            LINES = 8;
    localparam logic [AW-1:0] BASE  = 12'h040;
    localparam int            LOGN  = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          drain_req = 1'b0, drain_done;
    logic          mem_req_valid, mem_req_ready, mem_req_we;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    wb_window_cache #(.AW(AW), .DW(DW), .LINES(LINES), .BASE(BASE)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .drain_req(drain_req), .drain_done(drain_done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // ---------------- backing memory model ----------------
    logic [DW-1:0] bmem [LINES];
    logic [AW-1:0] wr_log [LOGN];
    logic [AW-1:0] rd_log [LOGN];
    int            wr_n = 0, rd_n = 0, bad_addr = 0;
    int            lat_min = 0, lat_max = 5;
    logic          pend = 1'b0;
    int            cnt = 0;
    logic [DW-1:0] rd_q = '0;

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 16'h03B1) ^ 16'hA55A);
    endfunction

    assign mem_req_ready = !pend;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= rd_q;
                pend          <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end else if (mem_req_valid) begin
            pend <= 1'b1;
            cnt  <= lat_min + int'($urandom % 32'(lat_max - lat_min + 1));
            if (mem_req_addr < BASE || mem_req_addr >= BASE + AW'(LINES)) begin
                bad_addr <= bad_addr + 1;
            end else if (mem_req_we) begin
                bmem[mem_req_addr - BASE] <= mem_req_wdata;
                if (wr_n < LOGN) wr_log[wr_n] <= mem_req_addr;
                wr_n <= wr_n + 1;
            end else begin
                rd_q <= bmem[mem_req_addr - BASE];
                if (rd_n < LOGN) rd_log[rd_n] <= mem_req_addr;
                rd_n <= rd_n + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    logic [DW-1:0] shadow [LINES];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cli_op(input bit we, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wdata, output logic [DW-1:0] rdata,
                          output bit got);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wdata;
        n = 0;
        while (!req_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        got   = rsp_valid;
        rdata = rsp_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        if (rsp_valid) got = 1'b0; // response must be a single-cycle pulse
    endtask

    task automatic do_read(input logic [AW-1:0] addr, input string tag);
        logic [DW-1:0] d; bit g; int idx;
        idx = int'(addr) % LINES;
        cli_op(1'b0, addr, '0, d, g);
        chk(g && d == shadow[idx], tag, int'(d), int'(shadow[idx]));
    endtask

    task automatic do_write(input logic [AW-1:0] addr, input logic [DW-1:0] v, input string tag);
        logic [DW-1:0] d; bit g;
        cli_op(1'b1, addr, v, d, g);
        shadow[int'(addr) % LINES] = v;
        chk(g && d == v, tag, int'(d), int'(v));
    endtask

    task automatic drain_and_check(input string tag);
        int n;
        @(negedge clk);
        drain_req = 1'b1;
        n = 0;
        while (!drain_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(drain_done, {tag, " drain_done"}, int'(drain_done), 1);
        for (int i = 0; i < LINES; i++)
            chk(bmem[i] == shadow[i], tag, int'(bmem[i]), int'(shadow[i]));
        drain_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d; bit g; int n, start, descents, hits;
        void'($urandom(32'd5150));
        for (int i = 0; i < LINES; i++) begin
            bmem[i]   = pat(i);
            shadow[i] = pat(i);
        end

        // R1: reset state and preload hold-off
        repeat (3) @(negedge clk);
        chk(!req_ready && !drain_done, "R1 reset outputs", int'(req_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_ready, "R1 ready low during preload", int'(req_ready), 0);
        n = 0;
        while (!req_ready && n < 2000) begin @(negedge clk); n++; end
        chk(req_ready, "R1 ready after preload", int'(req_ready), 1);
        chk(rd_n == LINES, "R1 preload read count", rd_n, LINES);
        for (int i = 0; i < LINES; i++)
            chk(rd_log[i] == BASE + AW'(i), "R1 preload order", int'(rd_log[i]), int'(BASE) + i);

        // R2: preloaded contents
        for (int i = 0; i < LINES; i++) do_read(AW'(i), "R2 preload data");

        // R4: upper address bits ignored
        do_read(AW'(12'hF03), "R4 alias read");
        do_write(AW'(12'h7A5), 16'h1234, "R3 write ack");
        do_read(AW'(12'h005), "R4 alias write then read");

        // R2/R3/R4: constrained random traffic
        for (int k = 0; k < 300; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            if ($urandom % 2 == 0) do_write(a, DW'($urandom), "R3 random write");
            else                   do_read(a, "R2 random read");
        end

        // R9: writes stall during drain, reads still served
        @(negedge clk);
        drain_req = 1'b1;
        req_valid = 1'b1; req_we = 1'b1; req_addr = '0; req_wdata = 16'hDEAD;
        #1;
        chk(!req_ready, "R9 write stalled in drain", int'(req_ready), 0);
        req_valid = 1'b0; req_we = 1'b0;
        do_read(AW'(3), "R9 read during drain");
        drain_and_check("R5 R8 drain contents");

        // R11: a fresh write keeps drain_done low
        lat_min = 4; lat_max = 6;
        do_write(AW'(2), 16'hBEEF, "R3 write before drain");
        drain_req = 1'b1;
        #1;
        chk(!drain_done, "R11 dirty blocks drain_done", int'(drain_done), 0);
        drain_req = 1'b0;
        drain_and_check("R11 drain after write");

        // R10: rewrite a line while its write-back is in flight
        lat_min = 10; lat_max = 10;
        start = wr_n;
        do_write(AW'(5), 16'hAAAA, "R3 first write");
        n = 0;
        while (!(wr_n > start && wr_log[wr_n-1] == BASE + AW'(5)) && n < 500) begin
            @(negedge clk); n++;
        end
        do_write(AW'(5), 16'h5555, "R3 rewrite in flight");
        drain_and_check("R10 rewritten line");
        hits = 0;
        for (int i = start; i < wr_n && i < LOGN; i++)
            if (wr_log[i] == BASE + AW'(5)) hits++;
        chk(hits >= 2, "R10 second write-back", hits, 2);

        // R7: ascending scan order with wrap
        lat_min = 30; lat_max = 30;
        for (int i = LINES - 1; i >= 0; i--) do_write(AW'(i), DW'($urandom), "R3 fill");
        start = wr_n;
        drain_and_check("R7 drain");
        descents = 0;
        for (int i = start + 1; i < wr_n && i < LOGN; i++)
            if (wr_log[i] <= wr_log[i-1]) descents++;
        chk(descents <= 1, "R7 scan order descents", descents, 1);
        chk(wr_n - start >= LINES - 1, "R7 lines written", wr_n - start, LINES - 1);

        // R5: external addresses stayed inside the window
        chk(bad_addr == 0, "R5 external address range", bad_addr, 0);
        finish_run();
    end
endmodule